// File: doc/BRIEF.md
# Burst-of-two double-data-rate SRAM controller

This block connects a single-data-rate request port to an external pipelined synchronous SRAM. The SRAM has separate input and output data buses, moves one word on each edge of its clock pair, and always transfers a burst of two words. A request carries a read/write flag, an address, a 36-bit write pair and four active-high byte enables. The controller turns each accepted request into one command cycle on the memory side, with the read/write select, an active-low load strobe and the address.

For a write, both words and their active-low byte-write strobes follow one cycle after the command. The two clock phases appear as a rise bus and a fall bus. A read's two returned words are captured and handed back as one 36-bit response. The response carries a one-cycle valid pulse and a sequence tag that counts reads in issue order.

Commands can be issued in every cycle, and reads and writes can be mixed freely. The write-data pipeline and the read-return pipeline run separately, so no idle cycle is needed between a write and a following read.

Top module: `b2ddr_ctrl`

## Requirements
- R1: While reset is asserted, req_ready is 0, mem_ld_n is 1, both byte-write strobe buses are all ones and rsp_valid is 0.
- R2: A request accepted at a clock edge (req_valid and req_ready high) appears on the memory lines for the whole next cycle. In that cycle mem_ld_n is 0, mem_addr equals req_addr, and mem_rw is 1 for a read (req_wr = 0) or 0 for a write.
- R3: In every cycle that follows an edge with no accepted request, mem_ld_n is 1 and mem_addr and mem_rw keep their previous values.
- R4: In the cycle after a write command is on the memory lines, three things hold. mem_d_rise carries write bits [17:0] and mem_d_fall carries bits [35:18]. mem_bw_rise_n equals the inverse of enables [1:0] and mem_bw_fall_n equals the inverse of enables [3:2]. Enable bit b governs data bits [9b+8:9b]. In all other cycles both strobe buses are all ones.
- R5: A read command on the memory lines in cycle C has its two words sampled from mem_q_rise and mem_q_fall at the end of cycle C+2. rsp_valid is high for cycle C+3 only, and rsp_rdata then equals {mem_q_fall, mem_q_rise}.
- R6: rsp_tag numbers the reads in issue order, starting at 0 after reset and wrapping modulo 2^TAG_W. Write commands do not advance the tag.
- R7: Requests accepted on consecutive edges, in any read/write mix, go out on consecutive cycles. Reads issued back to back produce back-to-back response pulses in issue order.
- R8: From the first cycle after reset is released, req_ready stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Burst address |
| req_wdata | input | 2*WW | Write pair, low word first |
| req_be | input | 2*WW/9 | Active-high byte enables |
| rsp_valid | output | 1 | Read response pulse |
| rsp_rdata | output | 2*WW | Returned pair, low word in low bits |
| rsp_tag | output | TAG_W | Read sequence number |
| mem_rw | output | 1 | Memory read/write select, 1 = read |
| mem_ld_n | output | 1 | Memory load strobe, active low |
| mem_addr | output | AW | Memory address |
| mem_d_rise | output | WW | Write word on the first phase |
| mem_d_fall | output | WW | Write word on the second phase |
| mem_bw_rise_n | output | WW/9 | Byte-write strobes, first phase, active low |
| mem_bw_fall_n | output | WW/9 | Byte-write strobes, second phase, active low |
| mem_q_rise | input | WW | Read word from the first phase |
| mem_q_fall | input | WW | Read word from the second phase |

## Verification
The bench issues a write followed at once by a read of the same address. A controller that stalled between them, or that put the write data in the wrong cycle, would return the old contents or shift the command stream. A partial-byte rewrite then checks that each enable reaches the strobe of its own phase and byte: swapped or uninverted strobes corrupt the merged readback. A stream of twenty reads tests that the response pulses are back to back and that tags step in issue order through the wrap. A pipeline stage off by one would misalign data and tags, and a tag counter that also counted writes would skip values.

// File: rtl/b2ddr_ctrl.sv
module b2ddr_ctrl #(
  parameter int AW    = 20,
  parameter int WW    = 18,
  parameter int TAG_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_wr,
  input  logic [AW-1:0]     req_addr,
  input  logic [2*WW-1:0]   req_wdata,
  input  logic [2*WW/9-1:0] req_be,
  output logic              rsp_valid,
  output logic [2*WW-1:0]   rsp_rdata,
  output logic [TAG_W-1:0]  rsp_tag,
  output logic              mem_rw,
  output logic              mem_ld_n,
  output logic [AW-1:0]     mem_addr,
  output logic [WW-1:0]     mem_d_rise,
  output logic [WW-1:0]     mem_d_fall,
  output logic [WW/9-1:0]   mem_bw_rise_n,
  output logic [WW/9-1:0]   mem_bw_fall_n,
  input  logic [WW-1:0]     mem_q_rise,
  input  logic [WW-1:0]     mem_q_fall
);
  localparam int NB = WW / 9;
  localparam int DW = 2 * WW;

  logic             rdy_q;
  logic             wv1;
  logic [DW-1:0]    wd1;
  logic [2*NB-1:0]  be1;
  logic [TAG_W-1:0] rd_cnt, tag_p0, tag_p1, tag_p2;
  logic             rd_p1, rd_p2;

  wire fire    = req_valid & rdy_q;
  wire rd_on_bus = ~mem_ld_n & mem_rw;
  assign req_ready = rdy_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rdy_q    <= 1'b0;
      mem_ld_n <= 1'b1;
      mem_rw   <= 1'b1;
      mem_addr <= '0;
      wv1      <= 1'b0;
      wd1      <= '0;
      be1      <= '0;
      rd_cnt   <= '0;
      tag_p0   <= '0;
    end else begin
      rdy_q    <= 1'b1;
      mem_ld_n <= ~fire;
      wv1      <= fire & req_wr;
      if (fire) begin
        mem_rw   <= ~req_wr;
        mem_addr <= req_addr;
      end
      if (fire & req_wr) begin
        wd1 <= req_wdata;
        be1 <= req_be;
      end
      if (fire & ~req_wr) begin
        tag_p0 <= rd_cnt;
        rd_cnt <= rd_cnt + 1'b1;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      mem_d_rise    <= '0;
      mem_d_fall    <= '0;
      mem_bw_rise_n <= '1;
      mem_bw_fall_n <= '1;
    end else begin
      mem_bw_rise_n <= wv1 ? ~be1[NB-1:0]    : '1;
      mem_bw_fall_n <= wv1 ? ~be1[2*NB-1:NB] : '1;
      if (wv1) begin
        mem_d_rise <= wd1[WW-1:0];
        mem_d_fall <= wd1[DW-1:WW];
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rd_p1     <= 1'b0;
      rd_p2     <= 1'b0;
      tag_p1    <= '0;
      tag_p2    <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_tag   <= '0;
    end else begin
      rd_p1     <= rd_on_bus;
      tag_p1    <= tag_p0;
      rd_p2     <= rd_p1;
      tag_p2    <= tag_p1;
      rsp_valid <= rd_p2;
      if (rd_p2) begin
        rsp_rdata <= {mem_q_fall, mem_q_rise};
        rsp_tag   <= tag_p2;
      end
    end
endmodule

// File: rtl/b2ddr_ctrl_chk.sv
module b2ddr_ctrl_chk #(
  parameter int AW = 20,
  parameter int WW = 18
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic            mem_ld_n,
  input logic            mem_rw,
  input logic [AW-1:0]   mem_addr,
  input logic [WW/9-1:0] mem_bw_rise_n,
  input logic [WW/9-1:0] mem_bw_fall_n,
  input logic            rsp_valid
);
  AST_CMD_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !mem_ld_n); // R2
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready) |=> (mem_ld_n && $stable(mem_addr) && $stable(mem_rw))); // R3
  AST_STROBE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_bw_rise_n != '1 || mem_bw_fall_n != '1) |-> $past(!mem_ld_n && !mem_rw)); // R4
  AST_RSP_FROM_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(!mem_ld_n && mem_rw, 3)); // R5
  AST_READY_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> req_ready); // R8
endmodule

bind b2ddr_ctrl b2ddr_ctrl_chk #(.AW(AW), .WW(WW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .mem_ld_n(mem_ld_n), .mem_rw(mem_rw), .mem_addr(mem_addr),
  .mem_bw_rise_n(mem_bw_rise_n), .mem_bw_fall_n(mem_bw_fall_n),
  .rsp_valid(rsp_valid));

// File: tb/sim_b2ddr_ctrl.sv
`timescale 1ns/1ps
module sim_b2ddr_ctrl;
  localparam int AW = 20, WW = 18, TAG_W = 4, NB = WW/9;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_wr = 0;
  logic [AW-1:0] req_addr = '0;
  logic [2*WW-1:0] req_wdata = '0;
  logic [2*NB-1:0] req_be = '0;
  logic req_ready, rsp_valid, mem_rw, mem_ld_n;
  logic [2*WW-1:0] rsp_rdata;
  logic [TAG_W-1:0] rsp_tag;
  logic [AW-1:0] mem_addr;
  logic [WW-1:0] mem_d_rise, mem_d_fall, mem_q_rise, mem_q_fall;
  logic [NB-1:0] mem_bw_rise_n, mem_bw_fall_n;

  int nchk = 0, nfail = 0;
  int rd_issued = 0;

  always #5 clk = ~clk;

  b2ddr_ctrl #(.AW(AW), .WW(WW), .TAG_W(TAG_W)) u0 (.*);

  // memory model: command sampled at an edge, data on the following edge
  logic [2*WW-1:0] ram [0:63];
  logic w_pend = 0, r_pend = 0;
  logic [5:0] w_a = '0, r_a = '0;

  function automatic logic [2*WW-1:0] seed(int i);
    return {18'(i * 13 + 5), 18'(i * 7 + 3)};
  endfunction

  function automatic logic [2*WW-1:0] merge(logic [2*WW-1:0] o, logic [2*WW-1:0] n,
                                           logic [2*NB-1:0] be);
    logic [2*WW-1:0] r = o;
    for (int b = 0; b < 2*NB; b++) if (be[b]) r[9*b +: 9] = n[9*b +: 9];
    return r;
  endfunction

  initial for (int i = 0; i < 64; i++) ram[i] = seed(i);

  always @(posedge clk) begin
    if (w_pend) begin
      for (int b = 0; b < NB; b++) begin
        if (!mem_bw_rise_n[b]) ram[w_a][9*b +: 9] <= mem_d_rise[9*b +: 9];
        if (!mem_bw_fall_n[b]) ram[w_a][WW + 9*b +: 9] <= mem_d_fall[9*b +: 9];
      end
    end
    if (r_pend) {mem_q_fall, mem_q_rise} <= ram[r_a];
    w_pend <= !mem_ld_n && !mem_rw;
    r_pend <= !mem_ld_n && mem_rw;
    w_a <= mem_addr[5:0];
    r_a <= mem_addr[5:0];
  end

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(bit v, bit wr, int a, logic [2*WW-1:0] d, logic [2*NB-1:0] be);
    req_valid = v; req_wr = wr; req_addr = AW'(a); req_wdata = d; req_be = be;
    if (v && !wr) rd_issued++;
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(req_ready == 0, "R1 ready", 64'(req_ready), 0);
    chk(mem_ld_n == 1, "R1 ld_n", 64'(mem_ld_n), 1);
    chk(mem_bw_rise_n == '1 && mem_bw_fall_n == '1, "R1 strobes",
        64'({mem_bw_fall_n, mem_bw_rise_n}), 64'hF);
    chk(rsp_valid == 0, "R1 rsp_valid", 64'(rsp_valid), 0);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready == 1, "R8 ready after reset", 64'(req_ready), 1);
    @(negedge clk);
    chk(req_ready == 1, "R8 ready held", 64'(req_ready), 1);
  endtask

  task automatic t_wr_rd;
    logic [2*WW-1:0] d = 36'h9_A5C3_1E27;
    drive(1, 1, 5, d, 4'hF);
    @(negedge clk);
    chk(!mem_ld_n && !mem_rw && mem_addr == 5, "R2 write cmd",
        64'({mem_ld_n, mem_rw, mem_addr}), 64'({1'b0, 1'b0, 20'd5}));
    drive(1, 0, 5, '0, '0);
    @(negedge clk);
    chk(mem_d_rise == d[17:0] && mem_d_fall == d[35:18], "R4 write data",
        64'({mem_d_fall, mem_d_rise}), 64'(d));
    chk(mem_bw_rise_n == 0 && mem_bw_fall_n == 0, "R4 full strobes",
        64'({mem_bw_fall_n, mem_bw_rise_n}), 0);
    chk(!mem_ld_n && mem_rw && mem_addr == 5, "R7 read right after write",
        64'({mem_ld_n, mem_rw}), 64'(2'b01));
    drive(0, 0, 0, '0, '0);
    @(negedge clk);
    chk(mem_ld_n && mem_rw && mem_addr == 5, "R3 idle holds",
        64'({mem_ld_n, mem_rw, mem_addr}), 64'({1'b1, 1'b1, 20'd5}));
    chk(mem_bw_rise_n == '1 && mem_bw_fall_n == '1, "R4 strobes idle after read",
        64'({mem_bw_fall_n, mem_bw_rise_n}), 64'hF);
    @(negedge clk);
    chk(rsp_valid == 0, "R5 not early", 64'(rsp_valid), 0);
    @(negedge clk);
    chk(rsp_valid == 1 && rsp_rdata == d, "R5 read returns write",
        64'(rsp_rdata), 64'(d));
    chk(rsp_tag == 0, "R6 first tag", 64'(rsp_tag), 0);
    @(negedge clk);
    chk(rsp_valid == 0, "R5 single pulse", 64'(rsp_valid), 0);
  endtask

  task automatic t_mask;
    logic [2*WW-1:0] d1 = 36'h1_2345_6789, d2 = 36'hF_EDCB_A987;
    logic [2*WW-1:0] exp = merge(d1, d2, 4'b0101);
    drive(1, 1, 7, d1, 4'hF);
    @(negedge clk);
    drive(1, 1, 7, d2, 4'b0101);
    @(negedge clk);
    drive(1, 0, 7, '0, '0);
    @(negedge clk);
    chk(mem_bw_rise_n == 2'b10 && mem_bw_fall_n == 2'b10, "R4 partial strobes",
        64'({mem_bw_fall_n, mem_bw_rise_n}), 64'(4'b1010));
    drive(0, 0, 0, '0, '0);
    @(negedge clk);
    chk(mem_ld_n && mem_rw && mem_addr == 7, "R3 idle after read",
        64'({mem_ld_n, mem_rw}), 64'(2'b11));
    @(negedge clk);
    @(negedge clk);
    chk(rsp_valid == 1 && rsp_rdata == exp, "R4 byte merge readback",
        64'(rsp_rdata), 64'(exp));
    chk(rsp_tag == 1, "R6 tag skips writes", 64'(rsp_tag), 1);
  endtask

  task automatic t_stream;
    int base = rd_issued;
    for (int k = 0; k < 25; k++) begin
      @(negedge clk);
      if (k >= 4 && k - 4 < 20) begin
        chk(rsp_valid == 1 && rsp_rdata == seed(20 + k - 4), "R7 stream data",
            64'(rsp_rdata), 64'(seed(20 + k - 4)));
        chk(rsp_tag == TAG_W'(base + k - 4), "R6 stream tag",
            64'(rsp_tag), 64'(TAG_W'(base + k - 4)));
      end else begin
        chk(rsp_valid == 0, "R5 no stray pulse", 64'(rsp_valid), 0);
      end
      if (k < 20) drive(1, 0, 20 + k, '0, '0);
      else drive(0, 0, 0, '0, '0);
    end
  endtask

  initial begin
    t_reset;
    t_wr_rd;
    t_mask;
    t_stream;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    #2000000;
    nchk++; nfail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule